// File: doc/BRIEF.md
# Power-on and pin reset sequencer

This block produces the active-low system reset for the main logic domain. It combines three inputs: a power-on reset, a low-voltage detector and an external active-low reset pin. It runs on a free-running internal clock that keeps going while the main domain is held in reset. All time intervals are counted in cycles of that clock and are set by parameters.

A cold start waits a fixed initialisation time after power-on, and the release moves later if the pin is still low or the voltage detector is still active. Reset is released at the latest of three events:

- the initialisation count expiring;
- the synchronised pin being seen high;
- the voltage detector having been clear for a release-delay count.

While the domain runs, a low on the pin causes a warm reset only once it has lasted a minimum number of cycles. A detector event always causes a reset.

A deep-sleep request parks the main domain in reset. A wake interrupt, any pin low or a detector event brings it out again. A two-bit cause output records what produced the most recent reset.

Top module: `rstseq_top`

## Requirements
- R1: While `por_rst_n` is low, `sys_rst_n` is 0 at once, without waiting for a clock edge, and `rst_cause` reads 2'b01 (power-on).
- R2: With the pin high and the detector clear, `sys_rst_n` rises on the (INIT_CYCLES+1)-th rising clock edge after `por_rst_n` goes high.
- R3: During a cold start, a pin held low past the initialisation time moves the release to the 3rd edge after the pin goes high. A pin that goes high earlier does not bring the release forward.
- R4: `sys_rst_n` goes low on the 3rd edge after `lvd_det` rises. It is released no earlier than the (LVD_REL_CYCLES+3)-th edge after `lvd_det` falls, and this holds both at cold start and while running. A detector event while running sets `rst_cause` to 2'b11.
- R5: While running, a pin low lasting L ≥ PIN_MIN_LOW edges pulls `sys_rst_n` low on the (PIN_MIN_LOW+3)-th edge after the fall. The release comes on edge max(L+3, PIN_MIN_LOW+4), and `rst_cause` becomes 2'b10.
- R6: While running, a pin low lasting fewer than PIN_MIN_LOW edges leaves `sys_rst_n` high and `rst_cause` unchanged.
- R7: A `stop2_req` seen while running pulls `sys_rst_n` low on the next edge, and it stays low after the request is withdrawn.
- R8: In deep sleep, a one-cycle `wake_irq` releases `sys_rst_n` on the 2nd edge, with `rst_cause` 2'b00.
- R9: In deep sleep, a pin low of any width, even one cycle, ends the sleep. `sys_rst_n` is released on the 3rd edge after the pin returns high, and `rst_cause` becomes 2'b10.
- R10: In deep sleep, a detector event ends the sleep with `rst_cause` 2'b11. Release follows the R4 rule.
- R11: `rst_cause` does not change while `sys_rst_n` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running internal clock |
| por_rst_n | input | 1 | Power-on reset, active low, asynchronous |
| pin_rst_n | input | 1 | External reset pin, active low, asynchronous to clk |
| lvd_det | input | 1 | Low-voltage detector, high while supply is low, asynchronous |
| stop2_req | input | 1 | Deep-sleep request, synchronous to clk |
| wake_irq | input | 1 | Deep-sleep wake interrupt, synchronous to clk |
| sys_rst_n | output | 1 | Main-domain reset, active low |
| rst_cause | output | 2 | Latest cause: 01 power-on, 10 pin, 11 voltage, 00 wake |

## Verification
The properties assume that `stop2_req` and `wake_irq` come from logic clocked by `clk`. They also assume that the pin and detector inputs are sampled only through the two-flop synchroniser. The bench therefore changes every input on the falling clock edge. It drives `wake_irq` for a single cycle and withdraws `stop2_req` as soon as the sleep is entered, so neither request is still present when the domain is released. Pin and detector timing is swept over several cycle offsets on either side of the initialisation and filter thresholds.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [1:0] {
    ST_INIT  = 2'd0,
    ST_RUN   = 2'd1,
    ST_HOLD  = 2'd2,
    ST_SLEEP = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    CAUSE_WAKE = 2'b00,
    CAUSE_POR  = 2'b01,
    CAUSE_PIN  = 2'b10,
    CAUSE_LVD  = 2'b11
  } rst_cause_e;

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int               WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  // one two-stage chain per bit, each with its own safe reset level
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[b] <= RST_VAL[b];
        stab_q[b] <= RST_VAL[b];
      end else begin
        meta_q[b] <= d_i[b];
        stab_q[b] <= meta_q[b];
      end
    end
  end

  assign q_o = stab_q;

endmodule

// File: rtl/rstseq_satcnt.sv
module rstseq_satcnt #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic done_o
);

  localparam int            CW  = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en = (cnt_q != LIM);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == LIM);

  // R5: the counter saturates and never passes its limit
  a_r5_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int INIT_CYCLES    = 2048,
  parameter int LVD_REL_CYCLES = 256,
  parameter int PIN_MIN_LOW    = 16
) (
  input  logic       clk,
  input  logic       por_rst_n,
  input  logic       pin_rst_n,
  input  logic       lvd_det,
  input  logic       stop2_req,
  input  logic       wake_irq,
  output logic       sys_rst_n,
  output logic [1:0] rst_cause
);

  // bit 1: detector (safe level = active), bit 0: pin (safe level = low)
  localparam logic [1:0] SYNC_RST = 2'b10;

  logic [1:0] sync_q;
  logic       pin_s;
  logic       lvd_s;
  logic       init_done;
  logic       lvd_ok;
  logic       pin_qual;
  logic       ready;

  seq_state_e state_q, state_d;
  rst_cause_e cause_q, cause_d;
  logic       sys_rst_n_q;

  rstseq_sync #(.WIDTH(2), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (por_rst_n),
    .d_i   ({lvd_det, pin_rst_n}),
    .q_o   (sync_q)
  );

  assign pin_s = sync_q[0];
  assign lvd_s = sync_q[1];

  rstseq_satcnt #(.LIMIT(INIT_CYCLES)) u_init_cnt (
    .clk    (clk),
    .rst_n  (por_rst_n),
    .clr_i  (1'b0),
    .done_o (init_done)
  );

  rstseq_satcnt #(.LIMIT(LVD_REL_CYCLES)) u_lvd_cnt (
    .clk    (clk),
    .rst_n  (por_rst_n),
    .clr_i  (lvd_s),
    .done_o (lvd_ok)
  );

  rstseq_satcnt #(.LIMIT(PIN_MIN_LOW)) u_pin_cnt (
    .clk    (clk),
    .rst_n  (por_rst_n),
    .clr_i  (pin_s),
    .done_o (pin_qual)
  );

  assign ready = init_done & lvd_ok & ~lvd_s & pin_s;

  always_comb begin
    state_d = state_q;
    cause_d = cause_q;
    unique case (state_q)
      ST_INIT: begin
        if (ready) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (lvd_s) begin
          state_d = ST_HOLD;
          cause_d = CAUSE_LVD;
        end else if (pin_qual) begin
          state_d = ST_HOLD;
          cause_d = CAUSE_PIN;
        end else if (stop2_req) begin
          state_d = ST_SLEEP;
        end
      end
      ST_HOLD: begin
        if (ready) state_d = ST_RUN;
      end
      ST_SLEEP: begin
        if (lvd_s) begin
          state_d = ST_HOLD;
          cause_d = CAUSE_LVD;
        end else if (!pin_s) begin
          state_d = ST_HOLD;
          cause_d = CAUSE_PIN;
        end else if (wake_irq) begin
          state_d = ST_HOLD;
          cause_d = CAUSE_WAKE;
        end
      end
      default: state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) begin
      state_q     <= ST_INIT;
      cause_q     <= CAUSE_POR;
      sys_rst_n_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      cause_q     <= cause_d;
      sys_rst_n_q <= (state_d == ST_RUN);
    end
  end

  assign sys_rst_n = sys_rst_n_q;
  assign rst_cause = cause_q;

  // R1/R2: no release while the initialisation count is still running
  a_r2_init_holds: assert property (@(posedge clk) disable iff (!por_rst_n)
    !init_done |=> !sys_rst_n);

  // R3: every release follows a high pin and an expired init count
  a_r3_release_needs_pin: assert property (@(posedge clk) disable iff (!por_rst_n)
    $rose(sys_rst_n) |-> ($past(pin_s) && $past(init_done)));

  // R4: an active detector always leads to reset
  a_r4_lvd_forces_reset: assert property (@(posedge clk) disable iff (!por_rst_n)
    lvd_s |=> !sys_rst_n);

  // R6: without a qualified low, a running domain stays released
  a_r6_short_low_ignored: assert property (@(posedge clk) disable iff (!por_rst_n)
    (state_q == ST_RUN && !pin_qual && !lvd_s && !stop2_req) |=> sys_rst_n);

  // R7: a sleep request while running parks the domain in reset
  a_r7_sleep_holds: assert property (@(posedge clk) disable iff (!por_rst_n)
    (state_q == ST_RUN && stop2_req) |=> !sys_rst_n);

  // R11: the cause is frozen while the domain stays released
  a_r11_cause_stable: assert property (@(posedge clk) disable iff (!por_rst_n)
    (sys_rst_n && $past(sys_rst_n)) |-> $stable(rst_cause));

endmodule

// File: tb/rstseq_top_bench.sv
module rstseq_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int INIT = 20;
  localparam int REL  = 5;
  localparam int MINL = 4;

  logic       clk = 1'b0;
  logic       por_rst_n = 1'b0;
  logic       pin_rst_n = 1'b1;
  logic       lvd_det = 1'b0;
  logic       stop2_req = 1'b0;
  logic       wake_irq = 1'b0;
  logic       sys_rst_n;
  logic [1:0] rst_cause;

  int  n_tests = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;
  int  exp_cause = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  rstseq_top #(
    .INIT_CYCLES    (INIT),
    .LVD_REL_CYCLES (REL),
    .PIN_MIN_LOW    (MINL)
  ) u_rstseq_top (
    .clk       (clk),
    .por_rst_n (por_rst_n),
    .pin_rst_n (pin_rst_n),
    .lvd_det   (lvd_det),
    .stop2_req (stop2_req),
    .wake_irq  (wake_irq),
    .sys_rst_n (sys_rst_n),
    .rst_cause (rst_cause)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // cold start: pin goes high after edge kp, detector clears after edge kl
  task automatic cold(input int kp, input int kl, output int rel_at);
    @(negedge clk);
    por_rst_n = 1'b0;
    #1;
    check("R1 async assert", int'(sys_rst_n), 0);
    check("R1 cause", int'(rst_cause), 1);
    pin_rst_n = (kp == 0);
    lvd_det   = (kl != 0);
    stop2_req = 1'b0;
    wake_irq  = 1'b0;
    tick();
    tick();
    check("R1 held", int'(sys_rst_n), 0);
    por_rst_n = 1'b1;
    rel_at = -1;
    for (int j = 1; j <= INIT + REL + kp + kl + 10; j++) begin
      tick();
      if (sys_rst_n && rel_at < 0) rel_at = j;
      if (j == kp) pin_rst_n = 1'b1;
      if (j == kl) lvd_det = 1'b0;
    end
    exp_cause = 1;
  endtask

  task automatic enter_sleep();
    stop2_req = 1'b1;
    tick();
    check("R7 sleep asserts", int'(sys_rst_n), 0);
    stop2_req = 1'b0;
    for (int k = 0; k < 3; k++) tick();
    check("R7 sleep held", int'(sys_rst_n), 0);
  endtask

  initial begin
    int kps[7];
    int kls[6];
    int rel;
    int first;
    int lows;
    kps = '{0, 5, INIT-3, INIT-2, INIT-1, INIT, INIT+3};
    kls = '{0, 3, INIT-8, INIT-4, INIT, INIT+2};

    // R2 R3 R4: release edge is the latest of the three conditions
    foreach (kps[a]) begin
      foreach (kls[b]) begin
        cold(kps[a], kls[b], rel);
        check("R2 R3 R4 cold release edge", rel,
              imax(INIT + 1, imax(kps[a] + 3, kls[b] + 3 + REL)));
      end
    end

    // R5 R6: warm pin pulses around the minimum width
    for (int len = 1; len <= MINL + 3; len++) begin
      pin_rst_n = 1'b0;
      first = -1;
      lows = 0;
      for (int j = 1; j <= len + MINL + 8; j++) begin
        tick();
        if (!sys_rst_n) begin
          lows++;
          if (first < 0) first = j;
        end
        if (j == len) pin_rst_n = 1'b1;
      end
      if (len < MINL) begin
        check("R6 short pulse no reset", lows, 0);
        check("R6 cause unchanged", int'(rst_cause), exp_cause);
      end else begin
        check("R5 warm assert edge", first, MINL + 3);
        check("R5 warm low width", lows, imax(len - MINL, 1));
        check("R5 cause pin", int'(rst_cause), 2);
        exp_cause = 2;
      end
      for (int k = 0; k < 3; k++) tick();
    end

    // R4: detector event while running
    for (int d = 1; d <= 6; d += (d == 2) ? 4 : 1) begin
      lvd_det = 1'b1;
      first = -1;
      lows = 0;
      for (int j = 1; j <= d + REL + 8; j++) begin
        tick();
        if (!sys_rst_n) begin
          lows++;
          if (first < 0) first = j;
        end
        if (j == d) lvd_det = 1'b0;
      end
      check("R4 run assert edge", first, 3);
      check("R4 run low width", lows, d + REL);
      check("R4 cause lvd", int'(rst_cause), 3);
      exp_cause = 3;
    end

    // R11: a filtered pulse leaves the cause alone
    pin_rst_n = 1'b0;
    for (int j = 1; j <= MINL + 8; j++) begin
      tick();
      if (j == MINL - 1) pin_rst_n = 1'b1;
    end
    check("R11 cause stable", int'(rst_cause), exp_cause);
    check("R11 still released", int'(sys_rst_n), 1);

    // R8: wake interrupt from deep sleep
    enter_sleep();
    wake_irq = 1'b1;
    first = -1;
    for (int j = 1; j <= 6; j++) begin
      tick();
      if (j == 1) wake_irq = 1'b0;
      if (sys_rst_n && first < 0) first = j;
    end
    check("R8 wake release edge", first, 2);
    check("R8 cause wake", int'(rst_cause), 0);

    // R9: any pin low ends deep sleep, no width filter
    for (int len = 1; len <= 3; len += 2) begin
      enter_sleep();
      pin_rst_n = 1'b0;
      first = -1;
      for (int j = 1; j <= len + 8; j++) begin
        tick();
        if (sys_rst_n && first < 0) first = j;
        if (j == len) pin_rst_n = 1'b1;
      end
      check("R9 pin wake release edge", first, len + 3);
      check("R9 cause pin", int'(rst_cause), 2);
    end

    // R10: detector event ends deep sleep
    enter_sleep();
    lvd_det = 1'b1;
    first = -1;
    for (int j = 1; j <= REL + 12; j++) begin
      tick();
      if (sys_rst_n && first < 0) first = j;
      if (j == 2) lvd_det = 1'b0;
    end
    check("R10 lvd wake release edge", first, 2 + 3 + REL);
    check("R10 cause lvd", int'(rst_cause), 3);

    // R1: power-on assertion from a running domain
    cold(0, 0, rel);
    check("R2 second cold release", rel, INIT + 1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule